// File: doc/BRIEF.md
# Single-Slot Deferred Event Timer

This block holds at most one deferred event and releases it when a free-running count of processor clock states reaches the event's due time. A requester offers an event identifier, an argument and a countdown. On acceptance the block stores the due time, which is the present count plus the countdown. At the first instruction boundary where the count has reached that due time, the block emits a one-cycle pulse carrying the identifier and the argument. The consumer of that pulse then performs the event's work.

A due time of zero is reserved to mean that the slot is empty. A sum that wraps to exactly zero is therefore stored as all ones. Only one event can wait at a time. If a new request arrives while the slot is occupied, the waiting event fires at once. The new request is held off by its handshake and is accepted in the following cycle. A cancel input empties the slot without firing anything. Status outputs show whether an event is waiting, its identifier and its due time.

Top module: `evt_slot_sched`

## Requirements
- R1: After reset, `pend_o` is 0, `pend_due_o` is 0, `fire_o` is 0 and `req_ready_o` is 1. Whenever the slot is empty, `pend_due_o` reads 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. From the next cycle, `pend_o` is 1, `pend_id_o` holds the identifier, and `pend_due_o` holds `tcount_i + req_delay_i` modulo 2^CW, using the count sampled at that edge.
- R3: If that sum is exactly zero, `pend_due_o` reads all ones. A stored due time is never zero while `pend_o` is 1.
- R4: On an edge where the slot is occupied, `step_i` is 1 and `tcount_i >= pend_due_o`, the event fires. In the next cycle `fire_o` is 1 for exactly one cycle, `fire_id_o` and `fire_arg_o` carry the stored identifier and argument, and `pend_o` is 0.
- R5: While the slot is occupied, an edge with `step_i` low (and no request and no cancel) does not fire the event, and an edge with `step_i` high does not fire it while the count is below the due time.
- R6: An event accepted with a countdown of 0 fires on the first edge after acceptance where `step_i` is 1.
- R7: `req_ready_o` is 0 while the slot is occupied. A request that is valid while the slot is occupied fires the waiting event on that edge, with the old identifier and argument. The request, if still valid, is accepted on the following edge.
- R8: On an edge with `cancel_i` high, the slot is emptied with no fire in the next cycle. `req_ready_o` is 0 while `cancel_i` is high, so a request in that cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tcount_i | input | CW | Free-running clock-state count |
| step_i | input | 1 | Instruction-boundary strobe; gates the due-time test |
| req_valid_i | input | 1 | Schedule request valid |
| req_ready_o | output | 1 | Slot can take a request this cycle |
| req_id_i | input | IDW | Event identifier to schedule |
| req_arg_i | input | AW | Event argument to schedule |
| req_delay_i | input | CW | Countdown in clock states |
| cancel_i | input | 1 | Drop the waiting event without firing |
| fire_o | output | 1 | One-cycle event pulse |
| fire_id_o | output | IDW | Identifier of the fired event |
| fire_arg_o | output | AW | Argument of the fired event |
| pend_o | output | 1 | An event is waiting |
| pend_id_o | output | IDW | Identifier of the waiting event |
| pend_due_o | output | CW | Due time of the waiting event, 0 when empty |

## Verification
A corrupted occupancy flag shows at the ports in the very next cycle. `req_ready_o` takes the wrong level, and `pend_o` disagrees with whether a pulse was last emitted. A bad due register shows as soon as it is stored, through `pend_due_o`. It also shows at the first strobed boundary afterwards, as a pulse that comes early, late or never. Because every output is compared against the reference model on every clock, a fault in the flush or cancel priority shows at the first cycle where two of those inputs coincide.

// File: rtl/evt_slot_sched.sv
module evt_slot_sched #(
  parameter int CW  = 64,
  parameter int IDW = 8,
  parameter int AW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  tcount_i,
  input  logic           step_i,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [IDW-1:0] req_id_i,
  input  logic [AW-1:0]  req_arg_i,
  input  logic [CW-1:0]  req_delay_i,
  input  logic           cancel_i,
  output logic           fire_o,
  output logic [IDW-1:0] fire_id_o,
  output logic [AW-1:0]  fire_arg_o,
  output logic           pend_o,
  output logic [IDW-1:0] pend_id_o,
  output logic [CW-1:0]  pend_due_o
);

  logic           busy_q, fire_q;
  logic [IDW-1:0] id_q, fid_q;
  logic [AW-1:0]  arg_q, farg_q;
  logic [CW-1:0]  due_q;

  wire [CW-1:0] due_sum = tcount_i + req_delay_i;
  wire [CW-1:0] due_new = (due_sum == '0) ? '1 : due_sum;
  wire          due_hit = step_i && (tcount_i >= due_q);
  wire          flush   = busy_q && (req_valid_i || due_hit);

  assign req_ready_o = !busy_q && !cancel_i;
  wire   take        = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fire_q <= 1'b0;
      id_q   <= '0;
      arg_q  <= '0;
      due_q  <= '0;
      fid_q  <= '0;
      farg_q <= '0;
    end else begin
      fire_q <= 1'b0;
      if (cancel_i) begin
        busy_q <= 1'b0;
        due_q  <= '0;
      end else if (flush) begin
        fire_q <= 1'b1;
        fid_q  <= id_q;
        farg_q <= arg_q;
        busy_q <= 1'b0;
        due_q  <= '0;
      end else if (take) begin
        busy_q <= 1'b1;
        id_q   <= req_id_i;
        arg_q  <= req_arg_i;
        due_q  <= due_new;
      end
    end
  end

  assign fire_o     = fire_q;
  assign fire_id_o  = fid_q;
  assign fire_arg_o = farg_q;
  assign pend_o     = busy_q;
  assign pend_id_o  = id_q;
  assign pend_due_o = due_q;

endmodule

// File: rtl/evt_slot_sched_chk.sv
module evt_slot_sched_chk #(
  parameter int CW  = 64,
  parameter int IDW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step_i,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic [IDW-1:0] req_id_i,
  input logic           cancel_i,
  input logic           fire_o,
  input logic           pend_o,
  input logic [IDW-1:0] pend_id_o,
  input logic [CW-1:0]  pend_due_o
);

  p_idle_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o |-> pend_due_o == '0);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (pend_o && pend_id_o == $past(req_id_i)));

  p_due_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> pend_due_o != '0);

  p_fire_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  p_fire_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> !pend_o);

  p_no_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !step_i && !req_valid_i && !cancel_i) |=> !fire_o);

  p_busy_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> !req_ready_o);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && req_valid_i && !cancel_i) |=> fire_o);

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (!fire_o && !pend_o));

endmodule

bind evt_slot_sched evt_slot_sched_chk #(.CW(CW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_id_i(req_id_i), .cancel_i(cancel_i),
  .fire_o(fire_o), .pend_o(pend_o), .pend_id_o(pend_id_o),
  .pend_due_o(pend_due_o)
);

// File: tb/evt_slot_sched_tb.sv
module evt_slot_sched_tb;
  localparam int CW = 64, IDW = 8, AW = 16;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] tcount = 64'd100;
  logic step = 0, rv = 0, cancel = 0;
  logic [IDW-1:0] rid = 0;
  logic [AW-1:0] rarg = 0;
  logic [CW-1:0] rdel = 0;
  logic ready, fire, pend;
  logic [IDW-1:0] fid, pid;
  logic [AW-1:0] farg;
  logic [CW-1:0] pdue;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_slot_sched #(.CW(CW), .IDW(IDW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tcount_i(tcount), .step_i(step),
    .req_valid_i(rv), .req_ready_o(ready), .req_id_i(rid), .req_arg_i(rarg),
    .req_delay_i(rdel), .cancel_i(cancel), .fire_o(fire), .fire_id_o(fid),
    .fire_arg_o(farg), .pend_o(pend), .pend_id_o(pid), .pend_due_o(pdue));

  // reference model
  bit m_busy, m_fire;
  logic [IDW-1:0] m_id, m_fid;
  logic [AW-1:0] m_arg, m_farg;
  logic [CW-1:0] m_due;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_fire = 0; m_due = 0;
    end else begin
      m_fire = 0;
      if (cancel) begin
        m_busy = 0; m_due = 0;
      end else if (m_busy && rv) begin
        m_fire = 1; m_fid = m_id; m_farg = m_arg; m_busy = 0; m_due = 0;
      end else if (m_busy && step && tcount >= m_due) begin
        m_fire = 1; m_fid = m_id; m_farg = m_arg; m_busy = 0; m_due = 0;
      end else if (!m_busy && rv) begin
        m_busy = 1; m_id = rid; m_arg = rarg; m_due = tcount + rdel;
        if (m_due == 0) m_due = {CW{1'b1}};
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act,
                     input logic [CW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    if (!rst_n) return;
    chk(pend == m_busy, "R2 pend", CW'(pend), CW'(m_busy));
    chk(pdue == m_due, "R2 due", pdue, m_due);
    if (m_busy) chk(pid == m_id, "R2 id", CW'(pid), CW'(m_id));
    chk(fire == m_fire, "R4 fire", CW'(fire), CW'(m_fire));
    if (m_fire) begin
      chk(fid == m_fid, "R4 fire id", CW'(fid), CW'(m_fid));
      chk(farg == m_farg, "R4 fire arg", CW'(farg), CW'(m_farg));
    end
    chk(ready == (!m_busy && !cancel), "R7 ready", CW'(ready), CW'(!m_busy && !cancel));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
    tcount = tcount + 1;
  endtask

  task automatic req(input logic [IDW-1:0] i, input logic [AW-1:0] a,
                     input logic [CW-1:0] d);
    rv = 1; rid = i; rarg = a; rdel = d;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    chk(!pend && pdue == 0 && !fire && ready, "R1 reset state",
        {fire, ready, pend}, 3'b010);

    // R2/R5/R4 basic schedule
    c = tcount;
    req(8'd5, 16'h1234, 64'd10);
    cyc();
    rv = 0;
    chk(pend && pdue == c + 10, "R2 due stored", pdue, c + 10);
    step = 0;
    for (int k = 0; k < 15; k++) begin
      cyc();
      chk(!fire, "R5 no fire without step", CW'(fire), 0);
    end
    chk(pend, "R5 still pending", CW'(pend), 1);
    step = 1;
    cyc();
    chk(fire && fid == 5 && farg == 16'h1234, "R4 fire payload", CW'(farg), 64'h1234);
    cyc();
    chk(!fire && !pend, "R4 single pulse", CW'({fire, pend}), 0);

    // R5 step high but not due
    step = 1;
    req(8'd9, 16'h0009, 64'd6);
    cyc(); rv = 0;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk(!fire, "R5 no fire before due", CW'(fire), 0);
    end
    repeat (4) cyc();

    // R6 zero countdown
    step = 1;
    req(8'd7, 16'hbeef, 64'd0);
    cyc(); rv = 0;
    cyc();
    chk(fire && fid == 7, "R6 zero countdown fires", CW'(fid), 7);
    cyc();

    // R3 wrap to zero
    step = 0;
    tcount = {CW{1'b1}} - 64'd4;
    req(8'd3, 16'h0003, 64'd5);
    cyc(); rv = 0;
    chk(pend && pdue == {CW{1'b1}}, "R3 wrapped due", pdue, {CW{1'b1}});

    // R8 cancel
    cancel = 1;
    cyc();
    cancel = 0;
    chk(!pend && !fire && pdue == 0, "R8 cancel empties", CW'({pend, fire}), 0);
    cyc();
    chk(!fire, "R8 no later fire", CW'(fire), 0);
    tcount = 64'd500;

    // R7 flush on reschedule
    req(8'd1, 16'h0101, 64'd1000);
    cyc();
    req(8'd2, 16'h0202, 64'd50);
    #0 chk(!ready, "R7 ready low while pending", CW'(ready), 0);
    cyc();
    chk(fire && fid == 1 && farg == 16'h0101, "R7 old event flushed", CW'(fid), 1);
    cyc();
    rv = 0;
    chk(!fire && pend && pid == 2, "R7 new event stored", CW'(pid), 2);

    // R8 cancel blocks request
    cancel = 1;
    cyc();
    req(8'd4, 16'h0404, 64'd3);
    #0 chk(!ready, "R8 ready low under cancel", CW'(ready), 0);
    cyc();
    cancel = 0; rv = 0;
    chk(!pend, "R8 request not taken", CW'(pend), 0);

    // random phase
    for (int k = 0; k < 600; k++) begin
      rv     = ($urandom_range(0, 9) < 3);
      rid    = IDW'($urandom);
      rarg   = AW'($urandom);
      rdel   = CW'($urandom_range(0, 40));
      step   = ($urandom_range(0, 2) != 0);
      cancel = ($urandom_range(0, 19) == 0);
      cyc();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule